// File: doc/BRIEF.md
# Two-Stage Black Offset Correction Controller

This block closes the black-level loop of an imaging front end. Once per line it receives the black-level error, which is the filtered black estimate minus its target. It then updates two sign-magnitude offset codes. The coarse code feeds a DAC ahead of the gain stage. The fine code feeds a DAC after the gain stage. One fine step is worth one converter LSB, and the fine code covers plus and minus 255 steps.

When the correction needed is larger than the fine range, the coarse code moves by exactly one code per line. It moves against the sign of the error. The fine code is preloaded with the residue, allowing for the expected weight of that coarse step. Once the residue fits in the fine range, control passes to the fine code. A flag shows which code is being adjusted.

Each DAC can be taken out of automatic control independently. It then follows a code written by software, and that code becomes the starting point when automatic control resumes. A debug port shows the flag together with either code.

Top module: `ofs_offset_ctrl`

## Requirements
- R1: After a synchronous reset, both codes are +0. The flag equals the start-order input: 1 means the fine code is adjusted first, 0 means the coarse code is adjusted first.
- R2: With both codes automatic and the flag at 1, an update with error e sets fine to fine−e when the result lies within ±255. The coarse code is unchanged.
- R3: With the flag at 1, if fine−e lies outside ±255, fine saturates at +255 or −255, the flag drops to 0, and coarse is unchanged.
- R4: With the flag at 0 and fine−e outside ±255, coarse moves one code: down for e>0, up for e<0. Fine becomes fine−e+w for e>0 or fine−e−w for e<0, saturated at ±255, where w is the coarse weight.
- R5: With the flag at 0 and fine−e within ±255, fine becomes fine−e, the flag rises to 1, and coarse is unchanged.
- R6: The coarse weight w is n shifted left by gain/134 (integer division). n is 4 for gain codes 0–63, 3 for 64–95, 2 for 96–127, and 1 for 128 and above.
- R7: A coarse code already at magnitude 255 does not move further in the same direction. It never wraps, and no fine compensation is added when it does not move.
- R8: Codes change only on a cycle where both line_done and cal_win are high, or while a DAC is bypassed.
- R9: A bypassed DAC takes its register value one clock later and ignores the error. Bypassing fine also places coarse under register control.
- R10: On return to automatic control, the loop continues from the register-loaded codes. While coarse is not automatic, the phase is reloaded from the start-order input.
- R11: With only fine automatic the flag reads 1. With fine bypassed the flag reads 0.
- R12: dbg_out is {flag, sign, magnitude} of the coarse code when dbg_sel=0, or of the fine code when dbg_sel=1.
- R13: A code with magnitude 0 always carries sign 0, including a −0 written to a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_done | input | 1 | One-cycle strobe: the error for this line is valid |
| cal_win | input | 1 | Calibration window; updates are allowed only while high |
| err | input | ERR_W | Black-level error, two's complement |
| gain | input | GAIN_W | Gain code, used for the coarse weight |
| coarse_byp | input | 1 | 1 = coarse code follows reg_coarse |
| fine_byp | input | 1 | 1 = fine code follows reg_fine (also forces coarse bypass) |
| fine_first | input | 1 | Start order: 1 = fine first, 0 = coarse first |
| reg_coarse | input | 9 | Written coarse code, bit 8 sign (1 = minus), bits 7:0 magnitude |
| reg_fine | input | 9 | Written fine code, same layout |
| dbg_sel | input | 1 | Debug select: 0 = coarse, 1 = fine |
| coarse_code | output | 9 | Coarse DAC code, sign-magnitude |
| fine_code | output | 9 | Fine DAC code, sign-magnitude |
| fine_active | output | 1 | 1 while the fine code is being corrected |
| dbg_out | output | 10 | {flag, sign, magnitude} of the selected code |

## Verification
Small errors that keep the fine code in range exercise plain fine tracking. Large positive and negative errors force the saturate-and-hand-over path, and then a sequence of single coarse steps until the residue fits. Residues chosen just above 255 at three gain settings give results that differ for each possible weight, so the weight table is checked rather than masked by saturation. Switching to bypass and back, with register values that carry −0 or differ from the running codes, shows that the register is followed, that the error is ignored, and which phase the loop restarts in.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    localparam int MAG_W  = 8;
    localparam int CODE_W = MAG_W + 1;
    localparam int CALC_W = 14;

    localparam logic signed [CALC_W-1:0] MAG_LIM = CALC_W'((1 << MAG_W) - 1);

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } smcode_t;

    typedef enum logic {
        PH_COARSE = 1'b0,
        PH_FINE   = 1'b1
    } phase_e;

    function automatic logic signed [CALC_W-1:0] to_int(input smcode_t c);
        logic signed [CALC_W-1:0] m;
        m = signed'({{(CALC_W-MAG_W){1'b0}}, c.mag});
        return c.neg ? -m : m;
    endfunction

    function automatic smcode_t from_int_sat(input logic signed [CALC_W-1:0] v);
        smcode_t r;
        logic signed [CALC_W-1:0] a;
        if (v > MAG_LIM) begin
            r.neg = 1'b0;
            r.mag = '1;
        end else if (v < -MAG_LIM) begin
            r.neg = 1'b1;
            r.mag = '1;
        end else begin
            a     = (v < 0) ? -v : v;
            r.neg = (v < 0);
            r.mag = a[MAG_W-1:0];
        end
        return r;
    endfunction

    function automatic smcode_t norm(input smcode_t c);
        smcode_t r;
        r.mag = c.mag;
        r.neg = c.neg && (c.mag != '0);
        return r;
    endfunction

endpackage

// File: rtl/ofs_weight.sv
module ofs_weight #(
    parameter int GAIN_W            = 10,
    parameter int WGT_W             = 10,
    parameter int TH_X4             = 64,
    parameter int TH_X3             = 96,
    parameter int TH_X2             = 128,
    parameter int CODES_PER_DOUBLING = 134
) (
    input  logic [GAIN_W-1:0] gain,
    output logic [WGT_W-1:0]  weight
);
    logic [2:0]        n_mult;
    logic [GAIN_W-1:0] shamt;

    always_comb begin
        if (gain < GAIN_W'(TH_X4))      n_mult = 3'd4;
        else if (gain < GAIN_W'(TH_X3)) n_mult = 3'd3;
        else if (gain < GAIN_W'(TH_X2)) n_mult = 3'd2;
        else                            n_mult = 3'd1;
        shamt  = gain / GAIN_W'(CODES_PER_DOUBLING);
        weight = WGT_W'(n_mult) << shamt;
    end
endmodule

// File: rtl/ofs_step_calc.sv
module ofs_step_calc
    import ofs_pkg::*;
#(
    parameter int ERR_W = 11,
    parameter int WGT_W = 10
) (
    input  smcode_t          fine_cur,
    input  smcode_t          coarse_cur,
    input  logic [ERR_W-1:0] err,
    input  logic [WGT_W-1:0] weight,
    output logic             fits,
    output smcode_t          fine_fit,
    output smcode_t          fine_adj,
    output smcode_t          coarse_next
);
    logic signed [CALC_W-1:0] e, f, c, t, cn, adj, w;
    logic                     moved;

    always_comb begin
        e  = signed'({{(CALC_W-ERR_W){err[ERR_W-1]}}, err});
        w  = signed'({{(CALC_W-WGT_W){1'b0}}, weight});
        f  = to_int(fine_cur);
        c  = to_int(coarse_cur);
        t  = f - e;
        fits = (t <= MAG_LIM) && (t >= -MAG_LIM);

        if (e > 0)      cn = c - 1;
        else if (e < 0) cn = c + 1;
        else            cn = c;
        moved = (cn != c) && (cn <= MAG_LIM) && (cn >= -MAG_LIM);
        if (!moved) cn = c;

        if (!moved)     adj = t;
        else if (e > 0) adj = t + w;
        else            adj = t - w;

        fine_fit    = from_int_sat(t);
        fine_adj    = from_int_sat(adj);
        coarse_next = from_int_sat(cn);
    end
endmodule

// File: rtl/ofs_dac_reg.sv
module ofs_dac_reg
    import ofs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bypass,
    input  smcode_t reg_val,
    input  logic    upd_en,
    input  smcode_t next_val,
    output smcode_t cur
);
    always_ff @(posedge clk) begin
        if (rst)         cur <= '0;
        else if (bypass) cur <= norm(reg_val);
        else if (upd_en) cur <= norm(next_val);
    end
endmodule

// File: rtl/ofs_offset_ctrl.sv
module ofs_offset_ctrl
    import ofs_pkg::*;
#(
    parameter int ERR_W  = 11,
    parameter int GAIN_W = 10,
    parameter int WGT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_done,
    input  logic              cal_win,
    input  logic [ERR_W-1:0]  err,
    input  logic [GAIN_W-1:0] gain,
    input  logic              coarse_byp,
    input  logic              fine_byp,
    input  logic              fine_first,
    input  logic [8:0]        reg_coarse,
    input  logic [8:0]        reg_fine,
    input  logic              dbg_sel,
    output logic [8:0]        coarse_code,
    output logic [8:0]        fine_code,
    output logic              fine_active,
    output logic [9:0]        dbg_out
);
    logic       coarse_auto, fine_auto, upd;
    logic       fits;
    phase_e     phase, start_phase;
    smcode_t    fine_cur, coarse_cur, fine_fit, fine_adj, coarse_next, fine_next;
    logic [WGT_W-1:0] weight;
    logic       fine_upd, coarse_upd;

    assign coarse_auto = !coarse_byp && !fine_byp;
    assign fine_auto   = !fine_byp;
    assign upd         = line_done && cal_win;
    assign start_phase = fine_first ? PH_FINE : PH_COARSE;

    ofs_weight #(.GAIN_W(GAIN_W), .WGT_W(WGT_W)) u_weight (
        .gain   (gain),
        .weight (weight)
    );

    ofs_step_calc #(.ERR_W(ERR_W), .WGT_W(WGT_W)) u_calc (
        .fine_cur    (fine_cur),
        .coarse_cur  (coarse_cur),
        .err         (err),
        .weight      (weight),
        .fits        (fits),
        .fine_fit    (fine_fit),
        .fine_adj    (fine_adj),
        .coarse_next (coarse_next)
    );

    always_ff @(posedge clk) begin
        if (rst || !coarse_auto) begin
            phase <= start_phase;
        end else if (upd) begin
            if (phase == PH_COARSE && fits)      phase <= PH_FINE;
            else if (phase == PH_FINE && !fits)  phase <= PH_COARSE;
        end
    end

    always_comb begin
        fine_next  = (coarse_auto && phase == PH_COARSE && !fits) ? fine_adj : fine_fit;
        fine_upd   = upd && fine_auto;
        coarse_upd = upd && coarse_auto && (phase == PH_COARSE) && !fits;
    end

    ofs_dac_reg u_fine_reg (
        .clk      (clk),
        .rst      (rst),
        .bypass   (fine_byp),
        .reg_val  (smcode_t'(reg_fine)),
        .upd_en   (fine_upd),
        .next_val (fine_next),
        .cur      (fine_cur)
    );

    ofs_dac_reg u_coarse_reg (
        .clk      (clk),
        .rst      (rst),
        .bypass   (!coarse_auto),
        .reg_val  (smcode_t'(reg_coarse)),
        .upd_en   (coarse_upd),
        .next_val (coarse_next),
        .cur      (coarse_cur)
    );

    assign coarse_code = coarse_cur;
    assign fine_code   = fine_cur;
    assign fine_active = coarse_auto ? (phase == PH_FINE) : fine_auto;
    assign dbg_out     = {fine_active, dbg_sel ? fine_cur : coarse_cur};
endmodule

// File: rtl/ofs_offset_ctrl_chk.sv
module ofs_offset_ctrl_chk
    import ofs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       line_done,
    input logic       cal_win,
    input logic       coarse_byp,
    input logic       fine_byp,
    input logic [8:0] reg_fine,
    input logic       dbg_sel,
    input logic [8:0] coarse_code,
    input logic [8:0] fine_code,
    input logic       fine_active,
    input logic [9:0] dbg_out
);
    logic signed [CALC_W-1:0] c_int;
    assign c_int = to_int(smcode_t'(coarse_code));

    p_no_minus_zero_r13: assert property (@(posedge clk) disable iff (rst)
        ((coarse_code[7:0] != 8'd0) || !coarse_code[8]) &&
        ((fine_code[7:0] != 8'd0) || !fine_code[8]));

    p_hold_no_update_r8: assert property (@(posedge clk) disable iff (rst)
        (!(line_done && cal_win) && !coarse_byp && !fine_byp)
        |=> ($stable(coarse_code) && $stable(fine_code)));

    p_coarse_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!coarse_byp && !fine_byp)
        |=> ((c_int - $past(c_int) <= 1) && (c_int - $past(c_int) >= -1)));

    p_fine_only_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (coarse_byp && !fine_byp) |-> fine_active);

    p_fine_follows_reg_r9: assert property (@(posedge clk) disable iff (rst)
        fine_byp |=> (fine_code == norm(smcode_t'($past(reg_fine)))));

    p_dbg_layout_r12: assert property (@(posedge clk) disable iff (rst)
        dbg_out == {fine_active, dbg_sel ? fine_code : coarse_code});
endmodule

bind ofs_offset_ctrl ofs_offset_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_done   (line_done),
    .cal_win     (cal_win),
    .coarse_byp  (coarse_byp),
    .fine_byp    (fine_byp),
    .reg_fine    (reg_fine),
    .dbg_sel     (dbg_sel),
    .coarse_code (coarse_code),
    .fine_code   (fine_code),
    .fine_active (fine_active),
    .dbg_out     (dbg_out)
);

// File: tb/ofs_offset_ctrl_bench.sv
module ofs_offset_ctrl_bench;
    localparam int ERR_W  = 11;
    localparam int GAIN_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              line_done = 1'b0;
    logic              cal_win = 1'b1;
    logic [ERR_W-1:0]  err = '0;
    logic [GAIN_W-1:0] gain = '0;
    logic              coarse_byp = 1'b0;
    logic              fine_byp = 1'b0;
    logic              fine_first = 1'b0;
    logic [8:0]        reg_coarse = '0;
    logic [8:0]        reg_fine = '0;
    logic              dbg_sel = 1'b0;
    logic [8:0]        coarse_code, fine_code;
    logic              fine_active;
    logic [9:0]        dbg_out;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [8:0] c;
        logic [8:0] f;
        logic       fl;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    ofs_offset_ctrl u_ofs_offset_ctrl (
        .clk(clk), .rst(rst), .line_done(line_done), .cal_win(cal_win),
        .err(err), .gain(gain), .coarse_byp(coarse_byp), .fine_byp(fine_byp),
        .fine_first(fine_first), .reg_coarse(reg_coarse), .reg_fine(reg_fine),
        .dbg_sel(dbg_sel), .coarse_code(coarse_code), .fine_code(fine_code),
        .fine_active(fine_active), .dbg_out(dbg_out)
    );

    // monitor: compares outputs after each update edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                n_tests++;
                if (coarse_code !== x.c || fine_code !== x.f || fine_active !== x.fl) begin
                    n_fail++;
                    $display("FAIL %s: coarse=%h fine=%h flag=%b expected coarse=%h fine=%h flag=%b",
                             x.tag, coarse_code, fine_code, fine_active, x.c, x.f, x.fl);
                end
            end
        end
    end

    task automatic push(input logic [8:0] c, input logic [8:0] f, input logic fl, input string tag);
        exp_t x;
        x.c = c; x.f = f; x.fl = fl; x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic step(input int e, input logic [8:0] c, input logic [8:0] f,
                        input logic fl, input string tag);
        @(negedge clk);
        err = ERR_W'(e);
        line_done = 1'b1;
        @(posedge clk);
        push(c, f, fl, tag);
        @(negedge clk);
        line_done = 1'b0;
    endtask

    task automatic idle_expect(input logic [8:0] c, input logic [8:0] f,
                               input logic fl, input string tag);
        @(posedge clk);
        push(c, f, fl, tag);
    endtask

    task automatic check_dbg(input logic [9:0] exp_v, input string tag);
        n_tests++;
        if (dbg_out !== exp_v) begin
            n_fail++;
            $display("FAIL %s: dbg_out=%h expected %h", tag, dbg_out, exp_v);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle_expect(9'h000, 9'h000, 1'b0, "R1 reset state coarse-first");

        // gain 0: weight 4
        step(100,  9'h000, 9'h164, 1'b1, "R5 coarse phase fits, hand to fine");
        step(-20,  9'h000, 9'h150, 1'b1, "R2 fine tracking");
        step(300,  9'h000, 9'h1FF, 1'b0, "R3 fine saturates and hands to coarse");
        step(200,  9'h101, 9'h1FF, 1'b0, "R4 coarse steps down one");
        step(10,   9'h102, 9'h1FF, 1'b0, "R4 coarse step two");
        step(5,    9'h103, 9'h1FF, 1'b0, "R4 coarse step three");
        step(-30,  9'h103, 9'h1E1, 1'b1, "R5 residue fits");

        @(negedge clk) cal_win = 1'b0;
        step(50,   9'h103, 9'h1E1, 1'b1, "R8 strobe outside window ignored");
        @(negedge clk) cal_win = 1'b1;
        step(-225, 9'h103, 9'h000, 1'b1, "R13 fine zero is plus zero");

        @(negedge clk) begin coarse_byp = 1'b1; reg_coarse = 9'h1FE; end
        idle_expect(9'h1FE, 9'h000, 1'b1, "R9 coarse follows register, R11 fine-only flag");
        step(-300, 9'h1FE, 9'h0FF, 1'b1, "R11 fine-only saturating update");

        @(negedge clk) begin coarse_byp = 1'b0; reg_coarse = 9'h005; end
        step(600,  9'h1FF, 9'h1FF, 1'b0, "R10 auto resumes from register value");
        step(600,  9'h1FF, 9'h1FF, 1'b0, "R7 coarse saturated, no wrap");

        @(negedge clk) begin
            fine_byp = 1'b1; reg_fine = 9'h105; reg_coarse = 9'h003; fine_first = 1'b1;
        end
        idle_expect(9'h003, 9'h105, 1'b0, "R9 fine bypass forces both, R11 flag 0");
        step(100,  9'h003, 9'h105, 1'b0, "R9 error ignored in bypass");
        @(negedge clk) reg_fine = 9'h100;
        idle_expect(9'h003, 9'h000, 1'b0, "R13 register minus zero normalized");

        @(negedge clk) begin fine_byp = 1'b0; gain = 10'd700; end
        idle_expect(9'h003, 9'h000, 1'b1, "R10 start order fine first");
        step(-400, 9'h003, 9'h0FF, 1'b0, "R3 positive saturation");
        step(-10,  9'h004, 9'h0E9, 1'b0, "R6 weight 32 at gain 700");
        @(negedge clk) gain = 10'd100;
        step(-23,  9'h005, 9'h0FE, 1'b0, "R6 weight 2 at gain 100");
        @(negedge clk) gain = 10'd300;
        step(-2,   9'h006, 9'h0FC, 1'b0, "R6 weight 4 at gain 300");
        step(0,    9'h006, 9'h0FC, 1'b1, "R5 zero error fits");

        @(negedge clk) dbg_sel = 1'b0;
        #1 check_dbg(10'h206, "R12 debug coarse view");
        @(negedge clk) dbg_sel = 1'b1;
        #1 check_dbg(10'h2FC, "R12 debug fine view");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule